// File: doc/BRIEF.md
# Signed Integer to Extended-Precision Float Converter

This block turns a two's-complement integer of 16, 32 or 64 bits (chosen by a parameter) into the 80-bit extended-precision floating-point layout. That layout has a sign bit, a 15-bit exponent biased by 16383, and a 64-bit mantissa whose top bit is an explicit integer bit. The block also produces the status word that an integer load leaves behind. The status word is built from the caller's current status word.

An operand and its status word are accepted on a valid/ready handshake. The converted value comes out of a single register stage one cycle later. The output is held while the consumer stalls. Internally the datapath finds the sign and forms the unsigned magnitude. A priority encoder locates the leading one, and a logarithmic shifter moves that bit to mantissa bit 63. The exponent is the leading-one index plus the bias.

Top module: `sint_to_xfloat`

## Requirements
- R1: An all-zero operand produces sign 0, exponent 0 and mantissa 0 (positive zero).
- R2: A negative operand produces sign 1, and the mantissa is formed from its two's-complement negation.
- R3: For a non-zero operand, the exponent is 16383 plus the bit index of the highest set bit of the magnitude.
- R4: For a non-zero operand, the magnitude is shifted left until its leading one sits in mantissa bit 63, and the vacated low bits are zero.
- R5: The output status word has bits 13:11 equal to 3'b111, and bits 8, 10 and 14 copied from the input status word. All other bits are 0.
- R6: The most negative operand of width W gives sign 1, mantissa 0x8000_0000_0000_0000 and exponent 16383+W-1.
- R7: in_ready equals !out_valid || out_ready. An operand accepted at a clock edge is presented with out_valid high after that edge. While out_valid is high and out_ready is low, the output and out_valid stay unchanged.
- R8: After a clock edge with rst_n low, out_valid is 0 and in_ready is 1.
- R9: An operand presented while in_valid is low, or while in_ready is low, is not taken. It produces no result, and the held output does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_data | input | IN_W | Two's-complement operand |
| in_status | input | 16 | Current status word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sign | output | 1 | Result sign |
| out_exp | output | 15 | Biased result exponent |
| out_mant | output | 64 | Mantissa with explicit integer bit at 63 |
| out_status | output | 16 | Updated status word |

## Verification
The bench runs three instances of the block, at 16, 32 and 64 bits, on the same stimulus. It aims at the following cases:
- Zero, which must not be normalised. A design that shifted zero or biased its exponent would report a value of 1.0 or 2^-something.
- The most negative value of each width. A design that negated it as a signed number would give a garbage or all-ones mantissa.
- Magnitudes at every power of two, and all-ones patterns. These expose an off-by-one in the encoder index or the shift amount as a halved or doubled value.
- Status words with every bit set. A design that leaked condition bit 9 or other flags into the result would be caught.
- Consumer stalls with new operands waiting. These expose a block that overwrites held data or drops results.

// File: rtl/xfc_pkg.sv
// Package: shared constants and helpers for the integer to extended-float converter.
// Assumes the 80-bit layout: 1 sign bit, 15-bit exponent, 64-bit mantissa with explicit integer bit.
package xfc_pkg;
    localparam int EXP_W     = 15;
    localparam int MANT_W    = 64;
    localparam int SW_W      = 16;
    localparam int EXP_BIAS  = 16383;
    localparam int SHAMT_W   = $clog2(MANT_W);

    // Status-word fields kept or forced by an integer load.
    localparam logic [SW_W-1:0] SW_KEEP_MASK = 16'h4500;  // bits 14, 10, 8
    localparam logic [SW_W-1:0] SW_TOP_SEVEN = 16'h3800;  // bits 13:11 = 7

    // Build the status word left by a load from the caller's status word.
    function automatic logic [SW_W-1:0] load_status(input logic [SW_W-1:0] cur);
        return (cur & SW_KEEP_MASK) | SW_TOP_SEVEN;
    endfunction
endpackage

// File: rtl/xfc_magnitude.sv
// Module: xfc_magnitude
// Splits a two's-complement operand into a sign and an unsigned magnitude, and flags zero.
// Assumes: the most negative value negates to itself, and that result is read as unsigned.
module xfc_magnitude #(
    parameter int IN_W = 64
) (
    input  logic [IN_W-1:0] data_i,
    output logic            sign_o,
    output logic [IN_W-1:0] mag_o,
    output logic            zero_o
);
    // Sign, magnitude by negation, and zero flag.
    always_comb begin
        sign_o = data_i[IN_W-1];
        mag_o  = sign_o ? (~data_i + IN_W'(1)) : data_i;
        zero_o = ~|data_i;
    end
endmodule

// File: rtl/xfc_lead_one.sv
// Module: xfc_lead_one
// Priority encoder: returns the index of the highest set bit of vec_i.
// Assumes: idx_o is only meaningful when found_o is high.
module xfc_lead_one #(
    parameter int W = 64,
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             found_o
);
    // Scan upward so that the highest set bit has the last word.
    always_comb begin
        idx_o   = '0;
        found_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                idx_o   = IDX_W'(i);
                found_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xfc_norm_shift.sv
// Module: xfc_norm_shift
// Logarithmic left shifter: one stage per bit of the shift amount.
// Assumes: bits shifted past the top are discarded and zeros enter from the bottom.
module xfc_norm_shift #(
    parameter int W = 64,
    localparam int STAGES = $clog2(W)
) (
    input  logic [W-1:0]      data_i,
    input  logic [STAGES-1:0] amt_i,
    output logic [W-1:0]      data_o
);
    logic [W-1:0] stage [0:STAGES];

    assign stage[0] = data_i;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Stage s shifts by 2**s when its amount bit is set.
            assign stage[s+1] = amt_i[s] ? (stage[s] << (1 << s)) : stage[s];
        end
    endgenerate

    assign data_o = stage[STAGES];
endmodule

// File: rtl/sint_to_xfloat.sv
// Module: sint_to_xfloat
// Converts an IN_W-bit signed integer to the 80-bit extended format, with load status word.
// Assumes: IN_W is 16, 32 or 64; single register stage; valid/ready on both sides.
module sint_to_xfloat
    import xfc_pkg::*;
#(
    parameter int IN_W = 64,
    localparam int IDX_W = $clog2(IN_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IN_W-1:0]   in_data,
    input  logic [SW_W-1:0]   in_status,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [MANT_W-1:0] out_mant,
    output logic [SW_W-1:0]   out_status
);
    logic              op_sign;
    logic [IN_W-1:0]   op_mag;
    logic              op_zero;
    logic [IDX_W-1:0]  lead_idx;
    logic              lead_found;
    logic [MANT_W-1:0] mag_wide;
    logic [SHAMT_W-1:0] sh_amt;
    logic [MANT_W-1:0] mant_norm;
    logic              nx_sign;
    logic [EXP_W-1:0]  nx_exp;
    logic [MANT_W-1:0] nx_mant;
    logic              accept;

    xfc_magnitude #(.IN_W(IN_W)) u_mag (
        .data_i (in_data),
        .sign_o (op_sign),
        .mag_o  (op_mag),
        .zero_o (op_zero)
    );

    xfc_lead_one #(.W(IN_W)) u_lead (
        .vec_i   (op_mag),
        .idx_o   (lead_idx),
        .found_o (lead_found)
    );

    // Widen the magnitude and derive the normalising shift.
    always_comb begin
        mag_wide = MANT_W'(op_mag);
        sh_amt   = SHAMT_W'(MANT_W - 1) - SHAMT_W'(lead_idx);
    end

    xfc_norm_shift #(.W(MANT_W)) u_shift (
        .data_i (mag_wide),
        .amt_i  (sh_amt),
        .data_o (mant_norm)
    );

    // Assemble the next result; zero bypasses the biasing and shift.
    always_comb begin
        if (op_zero) begin
            nx_sign = 1'b0;
            nx_exp  = '0;
            nx_mant = '0;
        end else begin
            nx_sign = op_sign;
            nx_exp  = EXP_W'(EXP_BIAS) + EXP_W'(lead_idx);
            nx_mant = mant_norm;
        end
    end

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    // Output valid flag: set on accept, cleared when drained with nothing new.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_valid <= 1'b0;
        else if (in_ready) out_valid <= in_valid;
    end

    // Result register: loads only when an operand is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sign   <= 1'b0;
            out_exp    <= '0;
            out_mant   <= '0;
            out_status <= '0;
        end else if (accept) begin
            out_sign   <= nx_sign;
            out_exp    <= nx_exp;
            out_mant   <= nx_mant;
            out_status <= load_status(in_status);
        end
    end

    // Zero results are positive zero with empty mantissa.
    assert_zero_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_exp == '0) |-> (out_mant == '0) && !out_sign);

    // Encoder index points at a set magnitude bit.
    assert_lead_one_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !op_zero |-> lead_found && op_mag[lead_idx]);

    // Biased exponent stays inside the range the width allows.
    assert_exp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_exp != '0) |->
            (out_exp >= EXP_W'(EXP_BIAS)) && (out_exp <= EXP_W'(EXP_BIAS + IN_W - 1)));

    // Shifter puts the leading one at the integer bit.
    assert_norm_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !op_zero |-> mant_norm[MANT_W-1]);

    // Held result has integer bit set exactly when non-zero.
    assert_held_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mant[MANT_W-1] == (out_exp != '0)));

    // Status word: top field seven, only kept bits besides.
    assert_status_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_status[13:11] == 3'b111)
                   && ((out_status & ~(SW_KEEP_MASK | SW_TOP_SEVEN)) == '0));

    // Stalled output holds still.
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_mant) && $stable(out_exp)
                                   && $stable(out_sign) && $stable(out_status));

    // Reset empties the stage.
    assert_reset_idle_R8: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // No operand is taken while the stage is blocked.
    assert_no_take_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/sint_to_xfloat_tb.sv
module sint_to_xfloat_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        s;
        logic [14:0] e;
        logic [63:0] m;
        logic [15:0] st;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic out_ready = 1'b1;
    logic [63:0] din = '0;
    logic [15:0] sin = '0;

    logic rdy64, rdy32, rdy16, ov64, ov32, ov16;
    logic s64, s32, s16;
    logic [14:0] e64, e32, e16;
    logic [63:0] m64, m32, m16;
    logic [15:0] st64, st32, st16;

    int checks = 0;
    int fails = 0;
    exp_t q64[$];
    exp_t q32[$];
    exp_t q16[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sint_to_xfloat #(.IN_W(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy64),
        .in_data(din), .in_status(sin), .out_valid(ov64), .out_ready(out_ready),
        .out_sign(s64), .out_exp(e64), .out_mant(m64), .out_status(st64));
    sint_to_xfloat #(.IN_W(32)) u_dut_w32 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy32),
        .in_data(din[31:0]), .in_status(sin), .out_valid(ov32), .out_ready(out_ready),
        .out_sign(s32), .out_exp(e32), .out_mant(m32), .out_status(st32));
    sint_to_xfloat #(.IN_W(16)) u_dut_w16 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy16),
        .in_data(din[15:0]), .in_status(sin), .out_valid(ov16), .out_ready(out_ready),
        .out_sign(s16), .out_exp(e16), .out_mant(m16), .out_status(st16));

    // Reference from sign, leading-one index and shift, per the requirements.
    function automatic exp_t ref_model(input int w, input logic [63:0] v, input logic [15:0] st);
        exp_t r;
        longint sv;
        logic [63:0] mag;
        int idx;
        sv = longint'(v << (64 - w)) >>> (64 - w);
        r.st = (st & 16'h4500) | 16'h3800;
        r.s = (sv < 0);
        mag = r.s ? 64'(-sv) : 64'(sv);
        if (mag == 0) begin
            r.s = 1'b0; r.e = '0; r.m = '0; r.tag = "R1";
        end else begin
            idx = 0;
            for (int i = 0; i < 64; i++) if (mag[i]) idx = i;
            r.e = 15'(16383 + idx);
            r.m = mag << (63 - idx);
            if (r.s && mag == (64'd1 << (w - 1))) r.tag = "R6";
            else if (r.s) r.tag = "R2/R4";
            else r.tag = "R3/R4";
        end
        return r;
    endfunction

    task automatic note(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic compare(input int w, input logic s, input logic [14:0] e,
                           input logic [63:0] m, input logic [15:0] st);
        exp_t x;
        int n;
        n = (w == 64) ? q64.size() : (w == 32) ? q32.size() : q16.size();
        if (n == 0) begin
            note(1'b0, $sformatf("R9 w=%0d unexpected result got m=%h expected none", w, m));
            return;
        end
        if (w == 64) x = q64.pop_front();
        else if (w == 32) x = q32.pop_front();
        else x = q16.pop_front();
        note(s == x.s && e == x.e && m == x.m,
             $sformatf("%s w=%0d got s=%b e=%h m=%h expected s=%b e=%h m=%h",
                       x.tag, w, s, e, m, x.s, x.e, x.m));
        note(st == x.st, $sformatf("R5 w=%0d got status=%h expected %h", w, st, x.st));
    endtask

    // Monitor: compare every completed output transfer against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (rst_n && out_ready) begin
                if (ov64) compare(64, s64, e64, m64, st64);
                if (ov32) compare(32, s32, e32, m32, st32);
                if (ov16) compare(16, s16, e16, m16, st16);
            end
        end
    end

    // Driver: present an operand until taken, pushing expectations at the take.
    task automatic send(input logic [63:0] v, input logic [15:0] st);
        bit taken;
        taken = 0;
        while (!taken) begin
            @(negedge clk);
            in_valid = 1'b1; din = v; sin = st;
            #1;
            if (rdy64) begin
                taken = 1;
                q64.push_back(ref_model(64, v, st));
                q32.push_back(ref_model(32, v, st));
                q16.push_back(ref_model(16, v, st));
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        note(1'b0, "watchdog expired got hung expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: idle after reset.
        note(!ov64 && !ov32 && !ov16, $sformatf("R8 got out_valid=%b expected 0", ov64));
        note(rdy64 && rdy16, $sformatf("R8 got in_ready=%b expected 1", rdy64));

        // Directed values: zero, unit, extremes, most negative per width.
        send(64'd0, 16'hFFFF);                    // R1
        send(64'd1, 16'h0000);
        send(-64'd1, 16'h4500);                   // R2
        send(64'd5, 16'hBAFF);
        send(-64'd5, 16'h0100);
        send(64'h7FFF, 16'h0400);
        send(64'hFFFF_FFFF_FFFF_8000, 16'h4000);  // R6 for 16-bit
        send(64'hFFFF_FFFF_8000_0000, 16'hFFFF);  // R6 for 32-bit
        send(64'h8000_0000_0000_0000, 16'h1234);  // R6 for 64-bit
        send(64'h7FFF_FFFF_FFFF_FFFF, 16'h0200);  // R5 bit 9 cleared
        send(64'h00F0_F0F0_F0F0_F0F0, 16'h5555);
        send(64'h0000_0000_0001_2345, 16'hAAAA);
        // R3/R4: every power of two and its negation.
        for (int i = 0; i < 64; i++) begin
            send(64'd1 << i, 16'(i * 977));
            send(-(64'd1 << i), 16'(i * 313));
        end

        // R9: operands with in_valid low are ignored.
        @(negedge clk);
        din = 64'hDEAD_BEEF_0000_1111;
        repeat (3) @(negedge clk);
        note(!ov64 && !ov16, $sformatf("R9 got out_valid=%b with in_valid low expected 0", ov64));

        // R7/R9: stall the consumer with an operand waiting.
        out_ready = 1'b0;
        send(64'h0000_0000_0000_0300, 16'h0000);
        @(negedge clk);
        held = m64;
        in_valid = 1'b1; din = 64'h1111_2222_3333_4444; sin = 16'hFFFF;
        #1;
        note(!rdy64 && !rdy32 && !rdy16, $sformatf("R7 got in_ready=%b while stalled expected 0", rdy64));
        repeat (3) @(negedge clk);
        note(ov64 && m64 == held, $sformatf("R7/R9 got m=%h held expected %h", m64, held));
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);

        // Random operands with varied magnitudes.
        for (int k = 0; k < 200; k++) begin
            logic [63:0] r;
            r = {$urandom, $urandom};
            r = 64'(longint'(r) >>> ($urandom % 64));
            send(r, 16'($urandom));
        end

        repeat (4) @(negedge clk);
        note(q64.size() == 0 && q32.size() == 0 && q16.size() == 0,
             $sformatf("R7 got %0d results outstanding expected 0", q64.size()));
        finish_run();
    end
endmodule